// File: doc/BRIEF.md
# DTE Modem Handshake Sequencer

This block sits on the terminal side of an asynchronous serial link and runs the modem-control exchange that comes before, during and after data transfer. The modem drives four status lines: data-set-ready, clear-to-send, carrier detect and ring. These lines cross into the block through two-flop synchronizers. The block drives data-terminal-ready and request-to-send back to the modem. It also gives the serial transmitter a `tx_allowed_o` gate, which the transmitter tests before it starts each character.

The host asks the block to originate a call, to answer one, or to bring up a dedicated line where no call is placed. The host holds the request high for as long as the session should last. Dropping the request starts an ordered teardown. While `tx_pending_i` is high, the block requests the line and opens the gate only after the modem grants it. `tx_busy_i` tells the block that a character is still being shifted out, and that character is never cut short.

Each waiting step is bounded by a cycle limit. When the limit runs out, the block returns to idle with both control lines low and raises a one-cycle error pulse.

Top module: `dte_link_seq`

## Requirements
- R1: After reset, `dtr_o`, `rts_o`, `tx_allowed_o` and `timeout_err_o` are all low.
- R2: When `call_req_i` rises with `dedicated_i` low, `dtr_o` goes high while `rts_o` stays low. The data phase (request-to-send) is reached only after data-set-ready and then carrier detect have been seen.
- R3: While the block waits for data-set-ready, a carrier detect that arrives first does not advance it: `rts_o` stays low even if `tx_pending_i` is high.
- R4: With `answer_req_i` high, `dtr_o` stays low until ring is seen. Ring then raises `dtr_o`, and data-set-ready followed by carrier detect lead to the data phase.
- R5: In the connected state, a high `tx_pending_i` raises `rts_o`. `tx_allowed_o` rises only after synchronized clear-to-send is high, and only after a cycle in which `rts_o` was already high.
- R6: If clear-to-send falls during sending, `tx_allowed_o` drops within three cycles while `rts_o` stays high. When clear-to-send returns, `tx_allowed_o` reopens.
- R7: `rts_o` is not dropped while `tx_busy_i` is high, so a character in flight completes. Once `tx_busy_i` falls with no work pending, `rts_o` falls within two cycles.
- R8: Teardown order: `rts_o` falls first. The block then waits for clear-to-send to fall, and then for both carrier detect and data-set-ready to fall, before `dtr_o` is lowered.
- R9: With `dedicated_i` high at call request, `dtr_o` is never driven high. Data-set-ready alone leads to the data phase.
- R10: A wait state that lasts `timeout_i` cycles (nonzero) with its condition unmet returns the block to idle. `dtr_o`, `rts_o` and `tx_allowed_o` go low, and `timeout_err_o` pulses high for exactly one cycle on the same edge.
- R11: `timeout_i` equal to zero disables the timeout, so a wait lasts indefinitely.
- R12: Loss of carrier detect or data-set-ready during the data phase forces teardown: `rts_o` and `tx_allowed_o` drop at once, and `dtr_o` falls only after both modem lines are low.
- R13: If a wait condition is met in the same cycle its timeout would expire, the block advances and no error is raised. Meeting the condition one cycle later gives a timeout.
- R14: If `call_req_i` and `answer_req_i` are both high in idle, the block originates: `dtr_o` rises without waiting for ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| modem_dsr_i | input | 1 | Data-set-ready from modem, asynchronous |
| modem_cts_i | input | 1 | Clear-to-send from modem, asynchronous |
| modem_cd_i | input | 1 | Carrier detect from modem, asynchronous |
| modem_ri_i | input | 1 | Ring indicator from modem, asynchronous |
| call_req_i | input | 1 | Host holds high to originate a session |
| answer_req_i | input | 1 | Host holds high to accept an incoming call |
| dedicated_i | input | 1 | Session is on a dedicated line, no call placed |
| tx_pending_i | input | 1 | Host has characters to send |
| tx_busy_i | input | 1 | Serial transmitter is shifting a character |
| timeout_i | input | TMO_W | Wait-state cycle limit, zero disables |
| dtr_o | output | 1 | Data-terminal-ready to modem |
| rts_o | output | 1 | Request-to-send to modem |
| tx_allowed_o | output | 1 | Gate tested by the transmitter before each character |
| timeout_err_o | output | 1 | One-cycle pulse when a wait state times out |

## Verification
The two functions that can land in one cycle are the expiry of a wait-state timeout and the arrival of the modem line that wait state is watching. The bench watches `dtr_o` rise to learn the exact cycle the data-set-ready wait began. It then drives data-set-ready so that, after the synchronizer delay, the line is first seen on the final counted cycle: `dtr_o` must stay high and no error pulse may appear. The same stimulus shifted one cycle later must give the timeout, with `dtr_o` falling together with the error pulse.

// File: rtl/dte_link_pkg.sv
package dte_link_pkg;

    typedef enum logic [3:0] {
        ST_IDLE         = 4'd0,
        ST_WAIT_DSR     = 4'd1,
        ST_WAIT_CD      = 4'd2,
        ST_WAIT_RI      = 4'd3,
        ST_CONNECTED    = 4'd4,
        ST_WAIT_CTS     = 4'd5,
        ST_SENDING      = 4'd6,
        ST_WAIT_CTS_LOW = 4'd7,
        ST_WAIT_DROP    = 4'd8
    } link_st_e;

    // Registered sequencer state; outputs are registered alongside it.
    typedef struct packed {
        link_st_e st;
        logic     ded;       // session runs on a dedicated line
        logic     teardown;  // cts-low wait leads to disconnect
        logic     dtr;
        logic     rts;
        logic     allow;
        logic     err;
    } link_reg_t;

    function automatic logic is_wait(link_st_e s);
        return (s == ST_WAIT_DSR) || (s == ST_WAIT_CD) || (s == ST_WAIT_RI) ||
               (s == ST_WAIT_CTS) || (s == ST_WAIT_CTS_LOW) || (s == ST_WAIT_DROP);
    endfunction

endpackage

// File: rtl/dte_link_sync.sv
module dte_link_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pipe_q[g] <= '0;
                else         pipe_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pipe_q[g] <= '0;
                else         pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dte_link_tmr.sv
module dte_link_tmr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             clr_i,    // sequencer changes state this cycle
    input  logic             run_i,    // next state is a wait state
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || !run_i)      cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        else                      cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // cnt_q holds the cycles already spent in the current wait state.
    assign expire_o = (limit_i != '0) && (cnt_q >= limit_i - 1'b1);

endmodule

// File: rtl/dte_link_fsm.sv
module dte_link_fsm
    import dte_link_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dsr_i,
    input  logic cts_i,
    input  logic cd_i,
    input  logic ri_i,
    input  logic call_req_i,
    input  logic answer_req_i,
    input  logic dedicated_i,
    input  logic tx_pending_i,
    input  logic tx_busy_i,
    input  logic expire_i,
    output logic chg_o,
    output logic run_o,
    output logic dtr_o,
    output logic rts_o,
    output logic allow_o,
    output logic err_o,
    output logic ded_o
);

    link_reg_t cur_q, nxt_d;

    logic sess_on, link_ok, quit, end_req;

    always_comb begin
        sess_on = call_req_i || answer_req_i;
        link_ok = dsr_i && (cur_q.ded || cd_i);
        quit    = !sess_on || !link_ok;
        end_req = quit || !tx_pending_i;

        nxt_d     = cur_q;
        nxt_d.err = 1'b0;

        unique case (cur_q.st)
            ST_IDLE: begin
                nxt_d.teardown = 1'b0;
                if (call_req_i) begin
                    nxt_d.ded = dedicated_i;
                    nxt_d.st  = ST_WAIT_DSR;
                end else if (answer_req_i) begin
                    nxt_d.ded = 1'b0;
                    nxt_d.st  = ST_WAIT_RI;
                end
            end
            ST_WAIT_RI: begin
                if (!answer_req_i) nxt_d.st = ST_IDLE;
                else if (ri_i)     nxt_d.st = ST_WAIT_DSR;
            end
            ST_WAIT_DSR: begin
                if (!sess_on)   nxt_d.st = ST_WAIT_DROP;
                else if (dsr_i) nxt_d.st = cur_q.ded ? ST_CONNECTED : ST_WAIT_CD;
            end
            ST_WAIT_CD: begin
                if (!sess_on)  nxt_d.st = ST_WAIT_DROP;
                else if (cd_i) nxt_d.st = ST_CONNECTED;
            end
            ST_CONNECTED: begin
                if (quit) begin
                    nxt_d.teardown = 1'b1;
                    nxt_d.st       = ST_WAIT_CTS_LOW;
                end else if (tx_pending_i) begin
                    nxt_d.st = ST_WAIT_CTS;
                end
            end
            ST_WAIT_CTS: begin
                if (end_req && !tx_busy_i) begin
                    nxt_d.teardown = quit;
                    nxt_d.st       = ST_WAIT_CTS_LOW;
                end else if (cts_i && !end_req) begin
                    nxt_d.st = ST_SENDING;
                end
            end
            ST_SENDING: begin
                if (end_req && !tx_busy_i) begin
                    nxt_d.teardown = quit;
                    nxt_d.st       = ST_WAIT_CTS_LOW;
                end else if (!cts_i) begin
                    nxt_d.st = ST_WAIT_CTS;
                end
            end
            ST_WAIT_CTS_LOW: begin
                if (!cts_i) nxt_d.st = cur_q.teardown ? ST_WAIT_DROP : ST_CONNECTED;
            end
            ST_WAIT_DROP: begin
                if (cur_q.ded || (!cd_i && !dsr_i)) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase

        // A wait that made no progress in its last allowed cycle ends the session.
        if (is_wait(cur_q.st) && expire_i && (nxt_d.st == cur_q.st)) begin
            nxt_d.st  = ST_IDLE;
            nxt_d.err = 1'b1;
        end

        nxt_d.dtr   = (nxt_d.st != ST_IDLE) && (nxt_d.st != ST_WAIT_RI) && !nxt_d.ded;
        nxt_d.rts   = (nxt_d.st == ST_WAIT_CTS) || (nxt_d.st == ST_SENDING);
        nxt_d.allow = (nxt_d.st == ST_SENDING) && !quit;

        chg_o = (nxt_d.st != cur_q.st);
        run_o = is_wait(nxt_d.st);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign dtr_o   = cur_q.dtr;
    assign rts_o   = cur_q.rts;
    assign allow_o = cur_q.allow;
    assign err_o   = cur_q.err;
    assign ded_o   = cur_q.ded;

endmodule

// File: rtl/dte_link_seq.sv
module dte_link_seq #(
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             modem_dsr_i,
    input  logic             modem_cts_i,
    input  logic             modem_cd_i,
    input  logic             modem_ri_i,
    input  logic             call_req_i,
    input  logic             answer_req_i,
    input  logic             dedicated_i,
    input  logic             tx_pending_i,
    input  logic             tx_busy_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             tx_allowed_o,
    output logic             timeout_err_o
);

    localparam int unsigned N_MODEM = 4;

    logic [N_MODEM-1:0] modem_raw, modem_s;
    logic dsr_s, cts_s, cd_s, ri_s;
    logic st_chg, tmr_run, tmr_expire, ded_q;

    assign modem_raw = {modem_ri_i, modem_cd_i, modem_cts_i, modem_dsr_i};
    assign dsr_s = modem_s[0];
    assign cts_s = modem_s[1];
    assign cd_s  = modem_s[2];
    assign ri_s  = modem_s[3];

    dte_link_sync #(
        .WIDTH  (N_MODEM),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (modem_raw),
        .sync_o  (modem_s)
    );

    dte_link_tmr #(
        .CNT_W (TMO_W)
    ) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .limit_i  (timeout_i),
        .clr_i    (st_chg),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    dte_link_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .dsr_i        (dsr_s),
        .cts_i        (cts_s),
        .cd_i         (cd_s),
        .ri_i         (ri_s),
        .call_req_i   (call_req_i),
        .answer_req_i (answer_req_i),
        .dedicated_i  (dedicated_i),
        .tx_pending_i (tx_pending_i),
        .tx_busy_i    (tx_busy_i),
        .expire_i     (tmr_expire),
        .chg_o        (st_chg),
        .run_o        (tmr_run),
        .dtr_o        (dtr_o),
        .rts_o        (rts_o),
        .allow_o      (tx_allowed_o),
        .err_o        (timeout_err_o),
        .ded_o        (ded_q)
    );

endmodule

// File: rtl/dte_link_chk.sv
module dte_link_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic dtr_i,
    input logic rts_i,
    input logic allow_i,
    input logic err_i,
    input logic busy_i,
    input logic dsr_s_i,
    input logic cd_s_i,
    input logic cts_s_i,
    input logic ded_i
);

    p_allow_after_rts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(allow_i) |-> $past(rts_i));

    p_allow_needs_cts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        allow_i |-> $past(cts_s_i));

    p_rts_keeps_char_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rts_i) |-> (err_i || !$past(busy_i)));

    p_dtr_drop_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dtr_i) |-> (err_i || (!$past(cd_s_i) && !$past(dsr_s_i))));

    p_ded_no_dtr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ded_i |-> !dtr_i);

    p_err_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> !err_i);

    p_err_idle_lines_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |-> (!dtr_i && !rts_i && !allow_i));

endmodule

bind dte_link_seq dte_link_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dtr_i   (dtr_o),
    .rts_i   (rts_o),
    .allow_i (tx_allowed_o),
    .err_i   (timeout_err_o),
    .busy_i  (tx_busy_i),
    .dsr_s_i (dsr_s),
    .cd_s_i  (cd_s),
    .cts_s_i (cts_s),
    .ded_i   (ded_q)
);

// File: tb/dte_link_seq_tb_top.sv
module dte_link_seq_tb_top;

    localparam int unsigned TMO_W = 16;
    localparam int N_VEC = 5;
    // {timeout limit, expected cycles dtr_o stays high before the error}
    localparam int TMO_VEC [N_VEC][2] = '{'{1, 1}, '{3, 3}, '{7, 7}, '{12, 12}, '{40, 40}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, dsr, cts, cd, ri, call_req, answer_req, dedicated, tx_pending, tx_busy;
    logic [TMO_W-1:0] tmo;
    logic dtr, rts, allowed, err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit err_seen = 1'b0;

    dte_link_seq #(.TMO_W(TMO_W)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .modem_dsr_i   (dsr),
        .modem_cts_i   (cts),
        .modem_cd_i    (cd),
        .modem_ri_i    (ri),
        .call_req_i    (call_req),
        .answer_req_i  (answer_req),
        .dedicated_i   (dedicated),
        .tx_pending_i  (tx_pending),
        .tx_busy_i     (tx_busy),
        .timeout_i     (tmo),
        .dtr_o         (dtr),
        .rts_o         (rts),
        .tx_allowed_o  (allowed),
        .timeout_err_o (err)
    );

    always @(posedge clk) if (err) err_seen <= 1'b1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_dtr_rise(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (dtr) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit ok;
        int cnt;
        rst_n = 1'b0; dsr = 0; cts = 0; cd = 0; ri = 0;
        call_req = 0; answer_req = 0; dedicated = 0; tx_pending = 0; tx_busy = 0;
        tmo = '0;
        cyc(3);
        // R1 reset state
        check("R1 dtr", dtr, 0);
        check("R1 rts", rts, 0);
        check("R1 allowed", allowed, 0);
        check("R1 err", err, 0);
        rst_n = 1'b1;
        cyc(2);

        // Timeout vectors, R10
        for (int v = 0; v < N_VEC; v++) begin
            tmo = TMO_VEC[v][0];
            call_req = 1'b1;
            wait_dtr_rise(ok);
            check("R10 dtr rose", int'(ok), 1);
            cnt = 0;
            while (dtr && cnt < 1000) begin
                cnt++;
                cyc(1);
            end
            check("R10 err pulse at fall", err, 1);
            check("R10 rts low", rts, 0);
            call_req = 1'b0;
            check("R10 wait length", cnt, TMO_VEC[v][1]);
            cyc(1);
            check("R10 err single", err, 0);
            cyc(3);
        end
        tmo = '0;

        // Originate path, R2 / R3 / R5 / R6 / R7 / R8
        call_req = 1'b1;
        cyc(4);
        check("R2 dtr up", dtr, 1);
        check("R2 rts low", rts, 0);
        cd = 1'b1; tx_pending = 1'b1;
        cyc(8);
        check("R3 cd before dsr no rts", rts, 0);
        check("R3 allowed low", allowed, 0);
        dsr = 1'b1;
        cyc(8);
        check("R2 data phase rts", rts, 1);
        check("R5 no gate before cts", allowed, 0);
        cts = 1'b1;
        cyc(4);
        check("R5 gate open", allowed, 1);
        cts = 1'b0;
        cyc(4);
        check("R6 gate closed", allowed, 0);
        check("R6 rts held", rts, 1);
        cts = 1'b1;
        cyc(4);
        check("R6 gate reopened", allowed, 1);
        tx_busy = 1'b1; tx_pending = 1'b0;
        cyc(6);
        check("R7 rts held while busy", rts, 1);
        tx_busy = 1'b0;
        cyc(2);
        check("R7 rts dropped", rts, 0);
        cts = 1'b0;
        cyc(4);
        check("R7 still connected dtr", dtr, 1);
        call_req = 1'b0;
        cyc(6);
        check("R8 dtr held with cd dsr", dtr, 1);
        cd = 1'b0;
        cyc(6);
        check("R8 dtr held with dsr", dtr, 1);
        dsr = 1'b0;
        cyc(4);
        check("R8 dtr dropped", dtr, 0);

        // Answer path, R4 / R8
        answer_req = 1'b1;
        cyc(6);
        check("R4 dtr low before ring", dtr, 0);
        ri = 1'b1;
        cyc(4);
        check("R4 dtr on ring", dtr, 1);
        ri = 1'b0; dsr = 1'b1; cd = 1'b1; tx_pending = 1'b1;
        cyc(8);
        check("R4 data phase rts", rts, 1);
        cts = 1'b1;
        cyc(4);
        check("R4 gate open", allowed, 1);
        answer_req = 1'b0;
        cyc(2);
        check("R8 rts first", rts, 0);
        check("R8 gate closed", allowed, 0);
        check("R8 dtr held", dtr, 1);
        cyc(6);
        check("R8 dtr held cts high", dtr, 1);
        cts = 1'b0;
        cyc(6);
        check("R8 dtr held modem up", dtr, 1);
        cd = 1'b0; dsr = 1'b0; tx_pending = 1'b0;
        cyc(4);
        check("R8 dtr released", dtr, 0);

        // Carrier loss, R12
        call_req = 1'b1; dsr = 1'b1; cd = 1'b1; tx_pending = 1'b1;
        cyc(10);
        check("R12 rts up", rts, 1);
        cts = 1'b1;
        cyc(4);
        check("R12 gate open", allowed, 1);
        cd = 1'b0;
        cyc(4);
        check("R12 rts forced low", rts, 0);
        check("R12 gate closed", allowed, 0);
        check("R12 dtr held", dtr, 1);
        cts = 1'b0;
        cyc(6);
        check("R12 dtr held dsr", dtr, 1);
        dsr = 1'b0; call_req = 1'b0; tx_pending = 1'b0;
        cyc(4);
        check("R12 dtr released", dtr, 0);

        // Dedicated line, R9
        dedicated = 1'b1; call_req = 1'b1;
        cyc(4);
        check("R9 no dtr", dtr, 0);
        dsr = 1'b1; tx_pending = 1'b1;
        cyc(8);
        check("R9 rts from dsr alone", rts, 1);
        check("R9 still no dtr", dtr, 0);
        cts = 1'b1;
        cyc(4);
        check("R9 gate open", allowed, 1);
        tx_pending = 1'b0; call_req = 1'b0;
        cyc(2);
        check("R9 rts dropped", rts, 0);
        cts = 1'b0; dsr = 1'b0;
        cyc(6);
        dedicated = 1'b0;
        check("R9 idle dtr", dtr, 0);

        // Timeout disabled, R11
        tmo = '0;
        err_seen = 1'b0;
        call_req = 1'b1;
        cyc(300);
        check("R11 dtr still waiting", dtr, 1);
        check("R11 no error", int'(err_seen), 0);
        call_req = 1'b0;
        cyc(4);
        check("R11 abort drops dtr", dtr, 0);

        // Progress versus expiry in the same cycle, R13
        tmo = 16'd6;
        err_seen = 1'b0;
        call_req = 1'b1;
        wait_dtr_rise(ok);
        cyc(3);
        dsr = 1'b1;
        cyc(3);
        check("R13 progress wins dtr", dtr, 1);
        check("R13 progress wins no err", int'(err_seen), 0);
        call_req = 1'b0; dsr = 1'b0;
        cyc(8);
        check("R13 back to idle", dtr, 0);
        call_req = 1'b1;
        wait_dtr_rise(ok);
        cyc(4);
        dsr = 1'b1;
        cyc(2);
        check("R13 late dsr times out dtr", dtr, 0);
        check("R13 late dsr err", err, 1);
        call_req = 1'b0; dsr = 1'b0;
        cyc(6);
        tmo = '0;

        // Both requests, R14
        call_req = 1'b1; answer_req = 1'b1;
        cyc(4);
        check("R14 originate wins", dtr, 1);
        call_req = 1'b0; answer_req = 1'b0;
        cyc(6);
        check("R14 idle after abort", dtr, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule